// File: doc/BRIEF.md
# Clock Health Status Flags

This block produces the read-only health flags that a clock controller exposes. One flag reports that the PLL lock interval has elapsed. A second reports that the low-power secondary oscillator has finished warming up. A third shows that the secondary oscillator has taken over its two pins. All three are produced from counters running on the reference clock. Nothing in the block observes the analog oscillators.

The lock flag depends only on a timer. The timer starts at power-on when the boot clock is PLL-derived, and it restarts on every switch strobe whose destination uses the PLL. A switch to a source without the PLL keeps the flag low until a later PLL switch. After the flag is set, it stays set until a power-on reset or a PLL-destination switch clears it. A lock loss during operation is not detected.

The secondary oscillator runs only when a configuration-level allow bit and a software enable are both high. While it runs, its pins are claimed and a warm-up counter counts to its limit. The ready flag sets when the count completes. Dropping either enable clears the ready flag and the count at once. The clock source selection does not affect the secondary oscillator.

Top module: `osc_health_status`

## Requirements
- R1: With the default boot source using the PLL, `pll_locked` is 0 up to and including the (LOCK_CYCLES-1)-th rising edge after `por_n` is released, and it is 1 from the LOCK_CYCLES-th edge on (default 2048).
- R2: While `por_n` is low, `pll_locked`, `sosc_ready` and `sosc_pins_owned` are all 0, whatever the other inputs are.
- R3: When `switch_stb` is high at an edge with `dest_uses_pll`=1, `pll_locked` is 0 after that edge. It stays 0 through LOCK_CYCLES-1 further edges and is 1 after the LOCK_CYCLES-th. A second such strobe during the interval restarts the full interval.
- R4: When `switch_stb` is high at an edge with `dest_uses_pll`=0, `pll_locked` is 0 after that edge. It stays 0 while that source remains selected.
- R5: After `pll_locked` is 1, it stays 1 for any number of cycles unless a strobe arrives. Changes on `dest_uses_pll` without `switch_stb` have no effect on it.
- R6: `sosc_pins_owned` is 1 after each edge at which `cfg_sosc_allow` and `sw_sosc_on` are both 1, and 0 after each edge at which either one is 0.
- R7: When both enables are sampled 1 on WARM_COUNT consecutive edges, counted from the first edge that samples them high, `sosc_ready` is 0 after edge WARM_COUNT-1 and 1 after edge WARM_COUNT (default 1024). It then stays 1 while both enables stay high.
- R8: An edge at which the oscillator is disabled clears `sosc_ready` after that edge. Re-enabling it, including in the middle of a warm-up, needs a full WARM_COUNT edges before `sosc_ready` sets again.
- R9: While `cfg_sosc_allow` is 0, `sw_sosc_on` has no effect: `sosc_ready` and `sosc_pins_owned` remain 0.
- R10: Clock switch strobes of either kind leave `sosc_ready` and `sosc_pins_owned` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all counters advance on its rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_sosc_allow | input | 1 | Configuration-level permission for the secondary oscillator |
| sw_sosc_on | input | 1 | Software enable of the secondary oscillator |
| switch_stb | input | 1 | One-cycle clock switch request |
| dest_uses_pll | input | 1 | Sampled with `switch_stb`: 1 if the destination source is PLL-derived |
| pll_locked | output | 1 | PLL lock-interval-elapsed flag |
| sosc_ready | output | 1 | Secondary oscillator warm-up complete |
| sosc_pins_owned | output | 1 | Secondary oscillator pins are claimed by the oscillator |

## Verification
The bench targets the exact edge on which each flag rises. An off-by-one counter would show up as a flag set one edge early or one edge late. A second PLL strobe in the middle of a lock interval checks that the interval restarts. A design that kept counting would set the lock flag too early. A disable in the middle of warm-up followed by a quick re-enable checks that the counter is cleared; a design that kept the partial count would report ready early. The bench also toggles the software enable while the configuration permission is low, which would expose gating logic that lets it through. It sends strobes of both kinds while the secondary oscillator is ready, which would expose coupling between the two halves.

// File: rtl/osc_status_pkg.sv
package osc_status_pkg;

    // Default lock interval in reference-clock cycles
    localparam int unsigned DEF_LOCK_CYCLES = 2048;
    // Default secondary oscillator warm-up length in cycles
    localparam int unsigned DEF_WARM_COUNT  = 1024;

    // Width needed to hold values 0..limit inclusive
    function automatic int unsigned span_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/pll_lock_timer.sv
module pll_lock_timer
    import osc_status_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = DEF_LOCK_CYCLES,
    parameter bit          BOOT_PLL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic switch_stb,
    input  logic dest_uses_pll,
    output logic locked
);

    localparam int unsigned CW = span_width(LOCK_CYCLES);
    localparam logic [CW-1:0] LOAD_VAL = CW'(LOCK_CYCLES);
    localparam logic [CW-1:0] LAST_VAL = CW'(1);

    typedef struct packed {
        logic          on_pll;
        logic          locked;
        logic [CW-1:0] left;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (switch_stb) begin
            // Any switch drops the flag; a PLL destination restarts the interval
            st_d.on_pll = dest_uses_pll;
            st_d.left   = LOAD_VAL;
            st_d.locked = 1'b0;
        end else if (!st_q.on_pll) begin
            st_d.left   = LOAD_VAL;
            st_d.locked = 1'b0;
        end else if (st_q.left != '0) begin
            st_d.left   = st_q.left - 1'b1;
            st_d.locked = (st_q.left == LAST_VAL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.on_pll <= BOOT_PLL;
            st_q.locked <= 1'b0;
            st_q.left   <= LOAD_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

    AST_LOCK_NONPLL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.on_pll |-> !locked);                                   // R4
    AST_LOCK_SWITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        switch_stb |=> !locked);                                     // R3
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !switch_stb) |=> locked);                         // R5
    AST_LOCK_RISE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && st_q.on_pll && !switch_stb && st_q.left > LAST_VAL) |=> !locked); // R1

endmodule

// File: rtl/sosc_warmup.sv
module sosc_warmup
    import osc_status_pkg::*;
#(
    parameter int unsigned WARM_COUNT = DEF_WARM_COUNT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_allow,
    input  logic sw_on,
    output logic ready,
    output logic pins_owned
);

    localparam int unsigned WW = span_width(WARM_COUNT);
    localparam logic [WW-1:0] FINAL_VAL = WW'(WARM_COUNT - 1);

    typedef struct packed {
        logic          own;
        logic          ready;
        logic [WW-1:0] cnt;
    } warm_st_t;

    warm_st_t st_d, st_q;
    logic     run_en;

    always_comb begin
        run_en = cfg_allow & sw_on;
        st_d   = st_q;
        st_d.own = run_en;
        if (!run_en) begin
            st_d.cnt   = '0;
            st_d.ready = 1'b0;
        end else if (!st_q.ready) begin
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.ready = (st_q.cnt == FINAL_VAL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready      = st_q.ready;
    assign pins_owned = st_q.own;

    AST_SOSC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_allow && sw_on) |=> (!ready && !pins_owned));          // R9
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cfg_allow && sw_on) |=> ready);                    // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= WW'(WARM_COUNT));                                // R7
    AST_READY_NEEDS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> pins_owned);                                       // R6

endmodule

// File: rtl/osc_health_status.sv
module osc_health_status
    import osc_status_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = DEF_LOCK_CYCLES,
    parameter int unsigned WARM_COUNT  = DEF_WARM_COUNT,
    parameter bit          BOOT_PLL    = 1'b1
) (
    input  logic clk_ref,
    input  logic por_n,
    input  logic cfg_sosc_allow,
    input  logic sw_sosc_on,
    input  logic switch_stb,
    input  logic dest_uses_pll,
    output logic pll_locked,
    output logic sosc_ready,
    output logic sosc_pins_owned
);

    pll_lock_timer #(
        .LOCK_CYCLES (LOCK_CYCLES),
        .BOOT_PLL    (BOOT_PLL)
    ) u_lock (
        .clk           (clk_ref),
        .rst_n         (por_n),
        .switch_stb    (switch_stb),
        .dest_uses_pll (dest_uses_pll),
        .locked        (pll_locked)
    );

    sosc_warmup #(
        .WARM_COUNT (WARM_COUNT)
    ) u_warm (
        .clk        (clk_ref),
        .rst_n      (por_n),
        .cfg_allow  (cfg_sosc_allow),
        .sw_on      (sw_sosc_on),
        .ready      (sosc_ready),
        .pins_owned (sosc_pins_owned)
    );

    // Switch strobes must not disturb the secondary oscillator flags
    AST_SOSC_IGNORES_SWITCH: assert property (@(posedge clk_ref) disable iff (!por_n)
        (switch_stb && cfg_sosc_allow && sw_sosc_on && sosc_ready) |=> sosc_ready); // R10

endmodule

// File: tb/osc_health_status_tb.sv
module osc_health_status_tb;

    localparam int unsigned N = 2048;
    localparam int unsigned W = 1024;
    localparam int SIG_LOCK  = 0;
    localparam int SIG_READY = 1;
    localparam int SIG_PINS  = 2;

    logic clk_ref = 1'b0;
    logic por_n, cfg_sosc_allow, sw_sosc_on, switch_stb, dest_uses_pll;
    logic pll_locked, sosc_ready, sosc_pins_owned;

    always #4 clk_ref = ~clk_ref;   // 125 MHz

    osc_health_status u_dut (
        .clk_ref         (clk_ref),
        .por_n           (por_n),
        .cfg_sosc_allow  (cfg_sosc_allow),
        .sw_sosc_on      (sw_sosc_on),
        .switch_stb      (switch_stb),
        .dest_uses_pll   (dest_uses_pll),
        .pll_locked      (pll_locked),
        .sosc_ready      (sosc_ready),
        .sosc_pins_owned (sosc_pins_owned)
    );

    typedef struct {
        int unsigned at;
        int          sig;
        logic        val;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always @(posedge clk_ref) cyc <= cyc + 1;

    // Driver side: push an expected value for a future edge count
    task automatic expect_at(input int unsigned at, input int sig, input logic val, input string tag);
        exp_t e;
        e.at = at; e.sig = sig; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic run(input int unsigned n);
        repeat (n) @(negedge clk_ref);
    endtask

    function automatic string sig_name(input int sig);
        case (sig)
            SIG_LOCK:  return "pll_locked";
            SIG_READY: return "sosc_ready";
            default:   return "sosc_pins_owned";
        endcase
    endfunction

    // Monitor: pop due expectations and compare at the falling edge
    always @(negedge clk_ref) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                logic act;
                case (sb[i].sig)
                    SIG_LOCK:  act = pll_locked;
                    SIG_READY: act = sosc_ready;
                    default:   act = sosc_pins_owned;
                endcase
                checks++;
                if (act !== sb[i].val) begin
                    errors++;
                    $display("FAIL %s: %s at edge %0d actual %b expected %b",
                             sb[i].tag, sig_name(sb[i].sig), cyc, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk_ref);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned c0, s, e, e2;
        por_n = 1'b0; cfg_sosc_allow = 1'b1; sw_sosc_on = 1'b1;
        switch_stb = 1'b0; dest_uses_pll = 1'b1;
        run(2);
        // R2: reset holds every flag low even with enables high
        expect_at(cyc + 1, SIG_LOCK,  1'b0, "R2");
        expect_at(cyc + 1, SIG_READY, 1'b0, "R2");
        expect_at(cyc + 2, SIG_PINS,  1'b0, "R2");
        run(3);
        sw_sosc_on = 1'b0;
        run(1);

        // R1 / R6 / R7: release reset and enable the oscillator together
        por_n = 1'b1; sw_sosc_on = 1'b1; c0 = cyc;
        expect_at(c0 + N - 1, SIG_LOCK,  1'b0, "R1");
        expect_at(c0 + N,     SIG_LOCK,  1'b1, "R1");
        expect_at(c0 + 1,     SIG_PINS,  1'b1, "R6");
        expect_at(c0 + W - 1, SIG_READY, 1'b0, "R7");
        expect_at(c0 + W,     SIG_READY, 1'b1, "R7");
        expect_at(c0 + N + 5, SIG_READY, 1'b1, "R7");
        run(N + 10);

        // R5: toggling the PLL marker without a strobe changes nothing
        dest_uses_pll = 1'b0;
        expect_at(cyc + 1000, SIG_LOCK, 1'b1, "R5");
        expect_at(cyc + 1400, SIG_LOCK, 1'b1, "R5");
        run(1500);
        dest_uses_pll = 1'b1;
        run(2);

        // R4 / R10: switch to a non-PLL source
        s = cyc; switch_stb = 1'b1; dest_uses_pll = 1'b0;
        expect_at(s + 1,     SIG_LOCK,  1'b0, "R4");
        expect_at(s + 1,     SIG_READY, 1'b1, "R10");
        expect_at(s + 1,     SIG_PINS,  1'b1, "R10");
        expect_at(s + N + 5, SIG_LOCK,  1'b0, "R4");
        run(1);
        switch_stb = 1'b0;
        run(N + 10);

        // R3: switch to a PLL source
        s = cyc; switch_stb = 1'b1; dest_uses_pll = 1'b1;
        expect_at(s + 1,     SIG_LOCK,  1'b0, "R3");
        expect_at(s + N,     SIG_LOCK,  1'b0, "R3");
        expect_at(s + N + 1, SIG_LOCK,  1'b1, "R3");
        expect_at(s + 1,     SIG_READY, 1'b1, "R10");
        run(1);
        switch_stb = 1'b0;
        run(N + 20);

        // R3: second PLL strobe mid-interval restarts the full interval
        s = cyc; switch_stb = 1'b1;
        run(1);
        switch_stb = 1'b0;
        run(299);
        s = cyc; switch_stb = 1'b1;
        expect_at(s + N,     SIG_LOCK, 1'b0, "R3");
        expect_at(s + N + 1, SIG_LOCK, 1'b1, "R3");
        run(1);
        switch_stb = 1'b0;
        run(N + 10);

        // R8: disable clears ready; partial warm-up is discarded
        s = cyc; sw_sosc_on = 1'b0;
        expect_at(s + 1, SIG_READY, 1'b0, "R8");
        expect_at(s + 1, SIG_PINS,  1'b0, "R6");
        run(10);
        e = cyc; sw_sosc_on = 1'b1;
        run(500);
        sw_sosc_on = 1'b0;
        run(10);
        e2 = cyc; sw_sosc_on = 1'b1;
        expect_at(e + W,      SIG_READY, 1'b0, "R8");
        expect_at(e2 + W - 1, SIG_READY, 1'b0, "R8");
        expect_at(e2 + W,     SIG_READY, 1'b1, "R8");
        run(W + 10);

        // R9: configuration permission low blocks the software enable
        s = cyc; cfg_sosc_allow = 1'b0;
        expect_at(s + 1, SIG_READY, 1'b0, "R9");
        expect_at(s + 1, SIG_PINS,  1'b0, "R9");
        run(20);
        sw_sosc_on = 1'b0;
        run(20);
        s = cyc; sw_sosc_on = 1'b1;
        expect_at(s + 1,      SIG_PINS,  1'b0, "R9");
        expect_at(s + W + 20, SIG_READY, 1'b0, "R9");
        expect_at(s + W + 20, SIG_PINS,  1'b0, "R9");
        run(W + 30);

        // R6 / R7: permission restored with software enable already high
        s = cyc; cfg_sosc_allow = 1'b1;
        expect_at(s + 1,     SIG_PINS,  1'b1, "R6");
        expect_at(s + W - 1, SIG_READY, 1'b0, "R7");
        expect_at(s + W,     SIG_READY, 1'b1, "R7");
        run(W + 10);

        run(2);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule